// File: doc/BRIEF.md
# Station Management Master with Background Status Polling

This block is the management-interface master that a network controller uses to reach its PHY over a two-wire clock and data link. Software writes one 32-bit control word. The word holds the transfer direction, the register number, the write data, a clock-rate select, a preamble-skip flag, an extended-addressing flag, a start flag and a polling enable. Software then reads the same word back until both the start flag and the busy flag are clear. When a read has finished, the 16 bits the PHY returned are in the low half of that word. The PHY port address is fixed at 0 by default.

For extended (two-stage) accesses, a second register written beforehand holds a device number and a 16-bit register address. The block then sends an address frame and after it the read or write frame. If polling is enabled and no start is pending, the block keeps reading PHY register 1 with no help from software. Each result is stored in the data field. Writing an all-zero word ends polling. The frame already on the wire still completes before the block goes idle.

Control word layout: bits [15:0] data, [20:16] register number, [21] read when 1 and write when 0, [22] skip the 32-bit preamble, [23] slow clock (MDC = clk/128 instead of clk/4), [24] extended mode, [25] start, [26] busy (read only), [27] polling enable, [31:28] zero. Extension register: bits [15:0] register address, [20:16] device number.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset the control word reads 0, MDC is low and the data line is not driven.
- R2: A word written with bit 25 set while idle reads back start=1/busy=0 in the next cycle and busy=1 in the cycle after that. Busy then stays high for exactly (frame bits × MDC period) cycles, and start reads 0 once busy falls.
- R3: A direct access sends 32 body bits MSB first: start 01, opcode 10 (read) or 01 (write), 5-bit port address 0, 5-bit register number, turnaround 10 on writes, then 16 data bits. The line is driven on every bit of a write.
- R4: On a read the master releases the line from the first turnaround bit through the last data bit. It samples the PHY on each MDC rising edge and leaves the 16 sampled bits in control bits [15:0].
- R5: The slow-clock bit selects an MDC period of 4 clock cycles when 0 and 128 when 1. MDC is held low while idle.
- R6: Each frame is preceded by 32 driven ones when bit 22 is 0, and by none when it is 1.
- R7: In extended mode the block sends an address frame (start 00, opcode 00, device number in the register-number slot, turnaround 10, extension address as data). This is followed by an access frame with start 00 and opcode 11 for read or 01 for write.
- R8: Writes to the control word while busy, other than all zeros, have no effect on the word or on the frames sent.
- R9: With bit 27 set and start clear, the block reads register 1 back to back, keeps busy high, and updates the data field with each result.
- R10: An all-zero write clears polling enable at once. The frame in progress finishes, no further frame starts, and an all-zero write while idle clears the whole word.
- R11: When start and polling enable are written together, the requested access is sent before the first polling read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock from which MDC is divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word write value |
| ctl_rdata | output | 32 | Control word read value, including busy |
| ext_we | input | 1 | Extension register write strobe (accepted while idle) |
| ext_wdata | input | 21 | Device number [20:16] and extended register address [15:0] |
| mdc | output | 1 | Management clock to the PHY |
| mdio_i | input | 1 | Data line as seen at the pad |
| mdio_o | output | 1 | Data line value to drive |
| mdio_oe | output | 1 | Drive enable for the data line |

## Verification
If the sequencer phase is wrong, a frame shows up at the pins with the wrong start or opcode bits, or with an extra or missing frame. The next word or two of MDC exposes it. If the bit counter or the preamble counter is off, the busy window has the wrong length. That shows when busy falls, which is at most one frame (256 cycles at the fast rate) after the fault. An output enable that is asserted at the wrong time changes the turnaround bits the bench observes, within the same frame. Corrupted capture logic leaves a wrong data field in the cycle busy drops.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int unsigned BODY_W = 32;
    localparam int unsigned DATA_W = 16;
    localparam int unsigned ADDR_W = 5;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_XFER = 2'd2,
        PH_POLL = 2'd3
    } phase_e;

    typedef struct packed {
        logic              ap_en;
        logic              start;
        logic              ext;
        logic              slow;
        logic              nopre;
        logic              rd;
        logic [ADDR_W-1:0] regad;
        logic [DATA_W-1:0] data;
    } ctl_word_t;

    function automatic ctl_word_t unpack_word(input logic [31:0] w);
        ctl_word_t c;
        c.data  = w[15:0];
        c.regad = w[20:16];
        c.rd    = w[21];
        c.nopre = w[22];
        c.slow  = w[23];
        c.ext   = w[24];
        c.start = w[25];
        c.ap_en = w[27];
        return c;
    endfunction

    // direct access body: start 01, opcode, port, register, turnaround, data
    function automatic logic [BODY_W-1:0] direct_body(input logic rd,
                                                       input logic [ADDR_W-1:0] port,
                                                       input logic [ADDR_W-1:0] regad,
                                                       input logic [DATA_W-1:0] data);
        return {2'b01, (rd ? 2'b10 : 2'b01), port, regad,
                (rd ? 2'b11 : 2'b10), (rd ? {DATA_W{1'b0}} : data)};
    endfunction

    // extended address body: start 00, opcode 00, device number, address as data
    function automatic logic [BODY_W-1:0] ext_addr_body(input logic [ADDR_W-1:0] port,
                                                         input logic [ADDR_W-1:0] dev,
                                                         input logic [DATA_W-1:0] addr);
        return {2'b00, 2'b00, port, dev, 2'b10, addr};
    endfunction

    // extended access body: start 00, opcode 11 read / 01 write
    function automatic logic [BODY_W-1:0] ext_op_body(input logic rd,
                                                       input logic [ADDR_W-1:0] port,
                                                       input logic [ADDR_W-1:0] dev,
                                                       input logic [DATA_W-1:0] data);
        return {2'b00, (rd ? 2'b11 : 2'b01), port, dev,
                (rd ? 2'b11 : 2'b10), (rd ? {DATA_W{1'b0}} : data)};
    endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int unsigned DIV_FAST = 4,
    parameter int unsigned DIV_SLOW = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic slow,
    output logic mdc,
    output logic rise,
    output logic fall
);
    localparam int unsigned HALF_FAST = DIV_FAST / 2;
    localparam int unsigned HALF_SLOW = DIV_SLOW / 2;
    localparam int unsigned CNT_W     = (HALF_SLOW > 1) ? $clog2(HALF_SLOW) : 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             mdc;
    } clk_state_t;

    clk_state_t s_d, s_q;
    logic [CNT_W-1:0] lim;

    always_comb begin
        lim  = slow ? CNT_W'(HALF_SLOW - 1) : CNT_W'(HALF_FAST - 1);
        s_d  = s_q;
        rise = 1'b0;
        fall = 1'b0;
        if (!run) begin
            s_d.cnt = '0;
            s_d.mdc = 1'b0;
        end else if (s_q.cnt >= lim) begin
            s_d.cnt = '0;
            s_d.mdc = ~s_q.mdc;
            rise    = ~s_q.mdc;
            fall    = s_q.mdc;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mdc = s_q.mdc;

endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
    import mdio_pkg::*;
#(
    parameter int unsigned PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BODY_W-1:0] ld_body,
    input  logic              ld_nopre,
    input  logic              ld_rd,
    input  logic              rise,
    input  logic              fall,
    input  logic              mdio_i,
    output logic              active,
    output logic              done,
    output logic [DATA_W-1:0] rx_data,
    output logic              mdio_o,
    output logic              mdio_oe
);
    localparam int unsigned TOT   = PRE_LEN + BODY_W;
    localparam int unsigned REM_W = $clog2(TOT + 1);
    // bits left when the read turnaround begins / when data begins
    localparam int unsigned TA_REM   = DATA_W + 2;
    localparam int unsigned DATA_REM = DATA_W;

    typedef struct packed {
        logic              active;
        logic              rd;
        logic [REM_W-1:0]  rem;
        logic [TOT-1:0]    sh;
        logic [DATA_W-1:0] rx;
    } sh_state_t;

    sh_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.active = 1'b1;
            s_d.rd     = ld_rd;
            s_d.rx     = '0;
            if (ld_nopre) begin
                s_d.rem = REM_W'(BODY_W);
                s_d.sh  = {ld_body, {PRE_LEN{1'b0}}};
            end else begin
                s_d.rem = REM_W'(TOT);
                s_d.sh  = {{PRE_LEN{1'b1}}, ld_body};
            end
        end else if (s_q.active) begin
            if (rise && s_q.rd && (s_q.rem <= REM_W'(DATA_REM))) begin
                s_d.rx = {s_q.rx[DATA_W-2:0], mdio_i};
            end
            if (fall) begin
                if (s_q.rem == REM_W'(1)) begin
                    s_d.active = 1'b0;
                end else begin
                    s_d.rem = s_q.rem - 1'b1;
                    s_d.sh  = {s_q.sh[TOT-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign active  = s_q.active;
    assign done    = s_q.active && fall && (s_q.rem == REM_W'(1));
    assign rx_data = s_q.rx;
    assign mdio_o  = s_q.active && s_q.sh[TOT-1];
    assign mdio_oe = s_q.active && !(s_q.rd && (s_q.rem <= REM_W'(TA_REM)));

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_pkg::*;
#(
    parameter int unsigned DIV_FAST = 4,
    parameter int unsigned DIV_SLOW = 128,
    parameter int unsigned PRE_LEN  = 32,
    parameter int unsigned PHY_ADDR = 0,
    parameter int unsigned POLL_REG = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctl_we,
    input  logic [31:0] ctl_wdata,
    output logic [31:0] ctl_rdata,
    input  logic        ext_we,
    input  logic [20:0] ext_wdata,
    output logic        mdc,
    input  logic        mdio_i,
    output logic        mdio_o,
    output logic        mdio_oe
);
    localparam logic [ADDR_W-1:0] PORT = ADDR_W'(PHY_ADDR);
    localparam logic [ADDR_W-1:0] PREG = ADDR_W'(POLL_REG);

    typedef struct packed {
        ctl_word_t cw;
        phase_e    ph;
        logic [20:0] ext;
    } top_state_t;

    top_state_t s_d, s_q;

    logic              load;
    logic [BODY_W-1:0] ld_body;
    logic              ld_rd;
    logic              sh_active;
    logic              sh_done;
    logic [DATA_W-1:0] sh_rx;
    logic              tick_rise;
    logic              tick_fall;
    logic              accept;
    logic              wr_zero;
    logic              busy;

    always_comb begin
        s_d     = s_q;
        load    = 1'b0;
        ld_body = '0;
        ld_rd   = 1'b0;
        accept  = (s_q.ph == PH_IDLE) && !s_q.cw.start && !s_q.cw.ap_en;
        wr_zero = ctl_we && (ctl_wdata == 32'd0);

        if (ctl_we) begin
            if (accept)       s_d.cw       = unpack_word(ctl_wdata);
            else if (wr_zero) s_d.cw.ap_en = 1'b0;
        end
        if (ext_we && accept) s_d.ext = ext_wdata;

        unique case (s_q.ph)
            PH_IDLE: begin
                if (s_q.cw.start) begin
                    load = 1'b1;
                    if (s_q.cw.ext) begin
                        ld_body = ext_addr_body(PORT, s_q.ext[20:16], s_q.ext[15:0]);
                        s_d.ph  = PH_ADDR;
                    end else begin
                        ld_body = direct_body(s_q.cw.rd, PORT, s_q.cw.regad, s_q.cw.data);
                        ld_rd   = s_q.cw.rd;
                        s_d.ph  = PH_XFER;
                    end
                end else if (s_q.cw.ap_en) begin
                    load    = 1'b1;
                    ld_body = direct_body(1'b1, PORT, PREG, '0);
                    ld_rd   = 1'b1;
                    s_d.ph  = PH_POLL;
                end
            end
            PH_ADDR: begin
                if (sh_done) begin
                    load    = 1'b1;
                    ld_body = ext_op_body(s_q.cw.rd, PORT, s_q.ext[20:16], s_q.cw.data);
                    ld_rd   = s_q.cw.rd;
                    s_d.ph  = PH_XFER;
                end
            end
            PH_XFER, PH_POLL: begin
                if (sh_done) begin
                    if (s_q.cw.rd || (s_q.ph == PH_POLL)) s_d.cw.data = sh_rx;
                    s_d.cw.start = 1'b0;
                    if (s_d.cw.ap_en) begin
                        load    = 1'b1;
                        ld_body = direct_body(1'b1, PORT, PREG, '0);
                        ld_rd   = 1'b1;
                        s_d.ph  = PH_POLL;
                    end else begin
                        s_d.ph  = PH_IDLE;
                    end
                end
            end
            default: s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cw  <= '0;
            s_q.ph  <= PH_IDLE;
            s_q.ext <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy = (s_q.ph != PH_IDLE);

    assign ctl_rdata = {4'b0000, s_q.cw.ap_en, busy, s_q.cw.start, s_q.cw.ext,
                        s_q.cw.slow, s_q.cw.nopre, s_q.cw.rd, s_q.cw.regad, s_q.cw.data};

    mdio_clkgen #(
        .DIV_FAST (DIV_FAST),
        .DIV_SLOW (DIV_SLOW)
    ) u_clkgen (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (sh_active),
        .slow  (s_q.cw.slow),
        .mdc   (mdc),
        .rise  (tick_rise),
        .fall  (tick_fall)
    );

    mdio_shifter #(
        .PRE_LEN (PRE_LEN)
    ) u_shifter (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .ld_body  (ld_body),
        .ld_nopre (s_q.cw.nopre),
        .ld_rd    (ld_rd),
        .rise     (tick_rise),
        .fall     (tick_fall),
        .mdio_i   (mdio_i),
        .active   (sh_active),
        .done     (sh_done),
        .rx_data  (sh_rx),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe)
    );

endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ctl_we,
    input logic [31:0] ctl_wdata,
    input logic [31:0] ctl_rdata,
    input logic        mdc,
    input logic        mdio_oe
);
    // start seen while not yet busy must turn into busy on the next edge
    p_start_to_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rdata[25] && !ctl_rdata[26]) |=> ctl_rdata[26]);

    p_start_clear_at_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl_rdata[26]) |-> !ctl_rdata[25]);

    p_idle_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_rdata[26] |-> !mdio_oe);

    p_mdc_parked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_rdata[26] |-> !mdc);

    p_busy_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rdata[26] && ctl_we && (ctl_wdata != 32'd0)) |=> $stable(ctl_rdata[24:16]));

    p_zero_stops_poll_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && (ctl_wdata == 32'd0)) |=> !ctl_rdata[27]);

endmodule

bind mdio_mgmt_ctrl mdio_mgmt_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_wdata),
    .ctl_rdata (ctl_rdata),
    .mdc       (mdc),
    .mdio_oe   (mdio_oe)
);

// File: tb/tb_mdio_mgmt_ctrl.sv
module tb_mdio_mgmt_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_we = 1'b0;
    logic [31:0] ctl_wdata = 32'd0;
    logic [31:0] ctl_rdata;
    logic        ext_we = 1'b0;
    logic [20:0] ext_wdata = 21'd0;
    logic        mdc;
    logic        mdio_i;
    logic        mdio_o;
    logic        mdio_oe;

    always #2.5 clk = ~clk;

    mdio_mgmt_ctrl dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_we    (ctl_we),
        .ctl_wdata (ctl_wdata),
        .ctl_rdata (ctl_rdata),
        .ext_we    (ext_we),
        .ext_wdata (ext_wdata),
        .mdc       (mdc),
        .mdio_i    (mdio_i),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe)
    );

    int     checks = 0;
    int     errors = 0;
    longint cyc = 0;
    bit     finished = 1'b0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int          pre;
        logic [31:0] body;
        logic [31:0] oe;
        longint      period;
        string       req;
    } exp_t;

    exp_t        expq[$];
    logic [15:0] phy_val = 16'h0000;
    bit          mon_in = 1'b0;
    int          mon_idx = 0;
    int          mon_ones = 0;
    int          frames_seen = 0;

    localparam logic [31:0] OE_WR = 32'hFFFF_FFFF;
    localparam logic [31:0] OE_RD = {14'h3FFF, 18'h0};

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mkw(input bit ap, input bit st, input bit ext, input bit slow,
                                        input bit nopre, input bit rd, input logic [4:0] ra,
                                        input logic [15:0] d);
        return {4'b0000, ap, 1'b0, st, ext, slow, nopre, rd, ra, d};
    endfunction

    task automatic push(input int pre, input logic [31:0] body, input logic [31:0] oe,
                        input longint period, input string req);
        exp_t e;
        e.pre = pre; e.body = body; e.oe = oe; e.period = period; e.req = req;
        expq.push_back(e);
    endtask

    // monitor: rebuilds each frame from the wire and scores it
    initial begin : monitor
        logic        b;
        logic [31:0] body;
        logic [31:0] oev;
        longint      last_rise;
        longint      prev_rise;
        exp_t        e;
        body = '0; oev = '0; last_rise = 0; prev_rise = 0;
        forever begin
            @(posedge mdc);
            #1;
            prev_rise = last_rise;
            last_rise = cyc;
            b = mdio_oe ? mdio_o : mdio_i;
            if (!mon_in) begin
                if (b) mon_ones++;
                else begin
                    mon_in = 1'b1; mon_idx = 1;
                    body = {31'b0, b}; oev = {31'b0, mdio_oe};
                end
            end else begin
                body = {body[30:0], b};
                oev  = {oev[30:0], mdio_oe};
                mon_idx++;
                if (mon_idx == 32) begin
                    if (expq.size() == 0) begin
                        chk(1'b0, "R8", "unexpected frame", body, 0);
                    end else begin
                        e = expq.pop_front();
                        chk(body == e.body, e.req, "frame body", body, e.body);
                        chk(mon_ones == e.pre, "R6", "preamble length", mon_ones, e.pre);
                        chk(oev == e.oe, "R4", "drive enable pattern", oev, e.oe);
                        chk((last_rise - prev_rise) == e.period, "R5", "mdc period",
                            last_rise - prev_rise, e.period);
                    end
                    frames_seen++;
                    mon_in = 1'b0; mon_idx = 0; mon_ones = 0;
                end
            end
        end
    end

    // PHY model: turnaround zero, then read data, changed after each falling MDC
    initial begin : phy_model
        mdio_i = 1'b1;
        forever begin
            @(negedge mdc);
            #1;
            if (mon_in && mon_idx >= 14 && mon_idx <= 15)      mdio_i = 1'b0;
            else if (mon_in && mon_idx >= 16 && mon_idx <= 31) mdio_i = phy_val[31 - mon_idx];
            else                                               mdio_i = 1'b1;
        end
    end

    task automatic wr_ctl(input logic [31:0] w);
        @(negedge clk);
        ctl_we = 1'b1; ctl_wdata = w;
        @(negedge clk);
        ctl_we = 1'b0; ctl_wdata = 32'd0;
    endtask

    task automatic wr_ext(input logic [20:0] w);
        @(negedge clk);
        ext_we = 1'b1; ext_wdata = w;
        @(negedge clk);
        ext_we = 1'b0; ext_wdata = 21'd0;
    endtask

    task automatic wait_idle(input string req);
        int guard;
        guard = 0;
        while (ctl_rdata[26] && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        chk(!ctl_rdata[26], req, "busy eventually clears", ctl_rdata[26], 0);
    endtask

    task automatic run_op(input logic [31:0] w, input int exp_cycles);
        int cnt;
        int guard;
        wr_ctl(w);
        chk(ctl_rdata[26:25] == 2'b01, "R2", "start set, busy not yet", ctl_rdata[26:25], 2'b01);
        @(negedge clk);
        chk(ctl_rdata[26], "R2", "busy one cycle after start", ctl_rdata[26], 1);
        cnt = 1; guard = 0;
        while (ctl_rdata[26] && guard < 20000) begin
            @(negedge clk);
            if (ctl_rdata[26]) cnt++;
            guard++;
        end
        chk(cnt == exp_cycles, "R2", "busy window length", cnt, exp_cycles);
        chk(!ctl_rdata[25], "R2", "start self-clears", ctl_rdata[25], 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stimulus
        int guard;
        int seen;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(ctl_rdata == 32'd0, "R1", "control word after reset", ctl_rdata, 0);
        chk(!mdc && !mdio_oe, "R1", "mdc low, line released", {mdc, mdio_oe}, 0);

        // R3: direct write with preamble, fast clock
        push(32, {2'b01, 2'b01, 5'd0, 5'd5, 2'b10, 16'hA55A}, OE_WR, 4, "R3");
        run_op(mkw(0, 1, 0, 0, 0, 0, 5'd5, 16'hA55A), 64 * 4);
        chk(expq.size() == 0, "R3", "write frame observed", expq.size(), 0);

        // R4: direct read without preamble
        phy_val = 16'h004D;
        push(0, {2'b01, 2'b10, 5'd0, 5'd2, 2'b00, 16'h004D}, OE_RD, 4, "R4");
        run_op(mkw(0, 1, 0, 0, 1, 1, 5'd2, 16'h0000), 32 * 4);
        chk(ctl_rdata[15:0] == 16'h004D, "R4", "read data returned", ctl_rdata[15:0], 16'h004D);

        // R5 slow clock read, R8 write while busy ignored
        phy_val = 16'hC3A1;
        push(0, {2'b01, 2'b10, 5'd0, 5'd3, 2'b00, 16'hC3A1}, OE_RD, 128, "R5");
        wr_ctl(mkw(0, 1, 0, 1, 1, 1, 5'd3, 16'h0000));
        repeat (600) @(negedge clk);
        seen = frames_seen;
        wr_ctl(mkw(0, 1, 1, 0, 0, 0, 5'd9, 16'h1111));
        wait_idle("R5");
        chk(ctl_rdata[24:16] == {1'b0, 1'b1, 1'b1, 1'b1, 5'd3}, "R8", "fields untouched by busy write",
            ctl_rdata[24:16], {1'b0, 1'b1, 1'b1, 1'b1, 5'd3});
        chk(ctl_rdata[15:0] == 16'hC3A1, "R8", "slow read data", ctl_rdata[15:0], 16'hC3A1);
        repeat (300) @(negedge clk);
        chk(frames_seen == seen + 1, "R8", "no frame from ignored write", frames_seen, seen + 1);

        // R7: extended write, with preamble
        wr_ext({5'd7, 16'h003C});
        push(32, {2'b00, 2'b00, 5'd0, 5'd7, 2'b10, 16'h003C}, OE_WR, 4, "R7");
        push(32, {2'b00, 2'b01, 5'd0, 5'd7, 2'b10, 16'hBEEF}, OE_WR, 4, "R7");
        run_op(mkw(0, 1, 1, 0, 0, 0, 5'd0, 16'hBEEF), 2 * 64 * 4);

        // R7: extended read, no preamble
        wr_ext({5'd3, 16'h8000});
        phy_val = 16'h5AC3;
        push(0, {2'b00, 2'b00, 5'd0, 5'd3, 2'b10, 16'h8000}, OE_WR, 4, "R7");
        push(0, {2'b00, 2'b11, 5'd0, 5'd3, 2'b00, 16'h5AC3}, OE_RD, 4, "R7");
        run_op(mkw(0, 1, 1, 0, 1, 1, 5'd0, 16'h0000), 2 * 32 * 4);
        chk(ctl_rdata[15:0] == 16'h5AC3, "R7", "extended read data", ctl_rdata[15:0], 16'h5AC3);

        // R11 start before polling, R9 polling, R10 stop
        phy_val = 16'h796D;
        push(0, {2'b01, 2'b01, 5'd0, 5'd4, 2'b10, 16'h01E1}, OE_WR, 4, "R11");
        for (int k = 0; k < 4; k++)
            push(0, {2'b01, 2'b10, 5'd0, 5'd1, 2'b00, 16'h796D}, OE_RD, 4, "R9");
        wr_ctl(mkw(1, 1, 0, 0, 1, 0, 5'd4, 16'h01E1));
        guard = 0;
        while (!(expq.size() == 1 && mon_in) && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        chk(ctl_rdata[26:25] == 2'b10, "R9", "polling busy with start clear", ctl_rdata[26:25], 2'b10);
        chk(ctl_rdata[15:0] == 16'h796D, "R9", "poll result in data field", ctl_rdata[15:0], 16'h796D);
        wr_ctl(32'd0);
        chk(!ctl_rdata[27] && ctl_rdata[26], "R10", "poll disabled, frame still running",
            ctl_rdata[27:26], 2'b01);
        wait_idle("R10");
        chk(expq.size() == 0, "R10", "final poll frame completed", expq.size(), 0);
        seen = frames_seen;
        repeat (300) @(negedge clk);
        chk(frames_seen == seen && !ctl_rdata[26], "R10", "no frame after stop", frames_seen, seen);

        // R10: zero write while idle clears the word
        wr_ctl(mkw(0, 0, 0, 1, 1, 1, 5'd17, 16'h1357));
        chk(ctl_rdata == mkw(0, 0, 0, 1, 1, 1, 5'd17, 16'h1357), "R10", "idle write loads word",
            ctl_rdata, mkw(0, 0, 0, 1, 1, 1, 5'd17, 16'h1357));
        wr_ctl(32'd0);
        chk(ctl_rdata == 32'd0, "R10", "idle zero write clears word", ctl_rdata, 0);
        repeat (50) @(negedge clk);
        chk(frames_seen == seen, "R10", "no frame without start", frames_seen, seen);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule